// File: doc/BRIEF.md
# Lockable GPIO Configuration Register Bank

This block is the software-visible register file of a 32-pin general purpose I/O controller. A simple word-addressed bus reaches it, with a one-cycle registered read. It holds the settings for the pins and for event detection: drive level, output enable, polarity, open-drain selection, pulls and input masking, plus event type, edge, enable and status. It presents every stored value on its own output port. It also emits a one-cycle strobe whenever a write has changed something that the pin resolver or the event detector must re-evaluate. Pin level resolution and event detection sit outside the block. The resolved input word and per-pin event hits arrive as inputs.

The output, output-enable and event-enable registers each have a pair of write-only alias addresses. One alias ORs the written bits into the register and the other clears them, so single bits can be changed without a read-modify-write. A two-key protocol can freeze the whole bank. Any write to either key address while the bank is open closes it. Reopening needs the second key value in the second key register, followed by the first key value written to the first key register. Slew, drive strength, debounce, mux and the four blink registers are plain storage.

Top module: `gpio_lock_bank`

## Requirements
- R1: After reset every register reads 0 and every configuration output is 0, except pull-up, pull-down, slew and drive strength, which hold the values of the parameters PU_RST, PD_RST, SLEW_RST and DRV_RST. The bank comes out of reset unlocked: word 0x00 reads 0 and `locked_o` is 0.
- R2: While unlocked, a write to any read/write register stores the word, and a later read returns it. The read/write registers are polarity 0x08, out 0x0C, OE 0x10, output type 0x14, mux 0x18, pull-up 0x1C, pull-down 0x20, debounce 0x24, event type 0x28, event edge 0x2C, blink 0x30/0x34/0x38/0x3C, event enable 0x40, input mask 0x58, slew 0x5C and drive 0x60. Each of these registers also drives its output port.
- R3: Word 0x04 reads the live `din_i` value, and writes to it have no effect. Reads return 0 at the write-only addresses (0x44, 0x48, 0x68, 0x6C, 0x70, 0x74, 0x7C), at the per-pin lock words 0x50/0x54 (writes to these are dropped) and at unmapped offsets.
- R4: While unlocked, a write of any value to 0x00 or 0x7C locks the bank: `locked_o` becomes 1, word 0x00 reads 1, and the second key is cleared to 0.
- R5: While locked, every write other than to 0x00 and 0x7C leaves all registers unchanged.
- R6: While locked, a write to 0x7C stores the second key. A write of 0xC0DEFA73 to 0x00 unlocks the bank only if the second key holds 0xC0DE1248, and unlocking clears both keys. Any other write to 0x00 keeps the bank locked.
- R7: A write to 0x68, 0x70 or 0x44 ORs the data into out, OE or event enable respectively. A write to 0x6C, 0x74 or 0x48 clears the bits that are 1 in the data.
- R8: Each bit of event status (0x4C) is set in the cycle after `evt_hit_i` is 1 for it. An unlocked write to 0x4C clears the bits that are 1 in the data. When a hit and a clear meet on the same bit in the same cycle, the bit ends up set.
- R9: `pins_upd_o` is 1 for exactly the cycle after an accepted write that changed polarity, out, OE, output type, pull-up, pull-down or input mask, and is 0 otherwise.
- R10: `evts_upd_o` is 1 for the cycle after an accepted write to event type, event edge, event enable, its set and clear aliases, or event status, and is 0 otherwise.
- R11: `bus_rdata` presents the addressed word in the cycle after `bus_re` is sampled high, and holds its value when `bus_re` is low.
- R12: An access whose address has nonzero bits [1:0] is misaligned: a write is ignored and a read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid one cycle after `bus_re` |
| din_i | input | NPINS | Resolved input word from the pin logic |
| evt_hit_i | input | NPINS | Per-pin event hits from the event logic |
| pol_o | output | NPINS | Polarity |
| dout_o | output | NPINS | Output level |
| oe_o | output | NPINS | Output enable |
| otyp_o | output | NPINS | Open-drain select |
| mux_o | output | NPINS | Mux/misc storage |
| pu_o | output | NPINS | Pull-up enable |
| pd_o | output | NPINS | Pull-down enable |
| dbnc_o | output | NPINS | Debounce storage |
| evtyp_o | output | NPINS | Event type (edge when 1) |
| evbe_o | output | NPINS | Event on both edges |
| even_o | output | NPINS | Event enable |
| evst_o | output | NPINS | Event status |
| iem_o | output | NPINS | Input enable mask |
| slew_o | output | NPINS | Slew storage |
| drv_o | output | NPINS | Drive strength storage |
| locked_o | output | 1 | Bank locked |
| pins_upd_o | output | 1 | Pin settings changed strobe |
| evts_upd_o | output | 1 | Event settings written strobe |

## Verification
A corrupt lock state makes itself felt at the next write. If the bank is wrongly open, a write meant to be blocked changes a configuration port and raises `pins_upd_o` one cycle later. If it is wrongly closed, a valid write is lost and the next read of that word returns the old value. A wrong second key shows only at the next unlock attempt, so the bench deliberately attempts an unlock right after a fresh lock. Errors in the alias or event-status merge show on the matching output port in the cycle after the write, and on `bus_rdata` two cycles after it.

// File: rtl/gpio_lock_bank.sv
module gpio_lock_bank #(
  parameter int NPINS = 32,
  parameter int ADDR_W = 8,
  parameter logic [NPINS-1:0] PU_RST = '0,
  parameter logic [NPINS-1:0] PD_RST = '0,
  parameter logic [NPINS-1:0] SLEW_RST = '0,
  parameter logic [NPINS-1:0] DRV_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_re,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  din_i,
  input  logic [NPINS-1:0]  evt_hit_i,
  output logic [NPINS-1:0]  pol_o,
  output logic [NPINS-1:0]  dout_o,
  output logic [NPINS-1:0]  oe_o,
  output logic [NPINS-1:0]  otyp_o,
  output logic [NPINS-1:0]  mux_o,
  output logic [NPINS-1:0]  pu_o,
  output logic [NPINS-1:0]  pd_o,
  output logic [NPINS-1:0]  dbnc_o,
  output logic [NPINS-1:0]  evtyp_o,
  output logic [NPINS-1:0]  evbe_o,
  output logic [NPINS-1:0]  even_o,
  output logic [NPINS-1:0]  evst_o,
  output logic [NPINS-1:0]  iem_o,
  output logic [NPINS-1:0]  slew_o,
  output logic [NPINS-1:0]  drv_o,
  output logic              locked_o,
  output logic              pins_upd_o,
  output logic              evts_upd_o
);
  localparam logic [ADDR_W-1:0] A_LOCK1 = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_DIN   = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_POL   = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_DOUT  = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_OE    = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_OTYP  = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] A_MUX   = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] A_PU    = ADDR_W'(8'h1C);
  localparam logic [ADDR_W-1:0] A_PD    = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] A_DBNC  = ADDR_W'(8'h24);
  localparam logic [ADDR_W-1:0] A_EVTYP = ADDR_W'(8'h28);
  localparam logic [ADDR_W-1:0] A_EVBE  = ADDR_W'(8'h2C);
  localparam logic [ADDR_W-1:0] A_BLK0  = ADDR_W'(8'h30);
  localparam logic [ADDR_W-1:0] A_BLK1  = ADDR_W'(8'h34);
  localparam logic [ADDR_W-1:0] A_BLK2  = ADDR_W'(8'h38);
  localparam logic [ADDR_W-1:0] A_BLK3  = ADDR_W'(8'h3C);
  localparam logic [ADDR_W-1:0] A_EVEN  = ADDR_W'(8'h40);
  localparam logic [ADDR_W-1:0] A_EVENS = ADDR_W'(8'h44);
  localparam logic [ADDR_W-1:0] A_EVENC = ADDR_W'(8'h48);
  localparam logic [ADDR_W-1:0] A_EVST  = ADDR_W'(8'h4C);
  localparam logic [ADDR_W-1:0] A_IEM   = ADDR_W'(8'h58);
  localparam logic [ADDR_W-1:0] A_SLEW  = ADDR_W'(8'h5C);
  localparam logic [ADDR_W-1:0] A_DRV   = ADDR_W'(8'h60);
  localparam logic [ADDR_W-1:0] A_DOS   = ADDR_W'(8'h68);
  localparam logic [ADDR_W-1:0] A_DOC   = ADDR_W'(8'h6C);
  localparam logic [ADDR_W-1:0] A_OES   = ADDR_W'(8'h70);
  localparam logic [ADDR_W-1:0] A_OEC   = ADDR_W'(8'h74);
  localparam logic [ADDR_W-1:0] A_LOCK2 = ADDR_W'(8'h7C);
  localparam logic [31:0] KEY1 = 32'hC0DE_FA73;
  localparam logic [31:0] KEY2 = 32'hC0DE_1248;

  logic [NPINS-1:0] pol_q, dout_q, oe_q, otyp_q, mux_q, pu_q, pd_q, dbnc_q;
  logic [NPINS-1:0] evtyp_q, evbe_q, even_q, evst_q, iem_q, slew_q, drv_q;
  logic [NPINS-1:0] pol_n, dout_n, oe_n, otyp_n, mux_n, pu_n, pd_n, dbnc_n;
  logic [NPINS-1:0] evtyp_n, evbe_n, even_n, evst_n, iem_n, slew_n, drv_n;
  logic [3:0][NPINS-1:0] blk_q, blk_n;
  logic [NPINS-1:0] evst_clr;
  logic             lk1_q, lk1_n;
  logic [31:0]      lk2_q, lk2_n;
  logic             evt_w, pins_upd_q, evts_upd_q;
  logic [31:0]      rd_val;

  wire              aligned = (bus_addr[1:0] == 2'b00);
  wire              wr_ok   = bus_we && aligned;
  wire [NPINS-1:0]  wv      = bus_wdata[NPINS-1:0];

  always_comb begin
    pol_n = pol_q;   dout_n = dout_q;  oe_n = oe_q;       otyp_n = otyp_q;
    mux_n = mux_q;   pu_n = pu_q;      pd_n = pd_q;       dbnc_n = dbnc_q;
    evtyp_n = evtyp_q; evbe_n = evbe_q; even_n = even_q; iem_n = iem_q;
    slew_n = slew_q; drv_n = drv_q;    blk_n = blk_q;
    lk1_n = lk1_q;   lk2_n = lk2_q;    evst_clr = '0;     evt_w = 1'b0;
    if (wr_ok) begin
      if (lk1_q) begin
        if (bus_addr == A_LOCK2) lk2_n = bus_wdata;
        else if (bus_addr == A_LOCK1 && lk2_q == KEY2 && bus_wdata == KEY1) begin
          lk1_n = 1'b0;
          lk2_n = '0;
        end
      end else begin
        case (bus_addr)
          A_LOCK1, A_LOCK2: begin lk1_n = 1'b1; lk2_n = '0; end
          A_POL:   pol_n  = wv;
          A_DOUT:  dout_n = wv;
          A_OE:    oe_n   = wv;
          A_OTYP:  otyp_n = wv;
          A_MUX:   mux_n  = wv;
          A_PU:    pu_n   = wv;
          A_PD:    pd_n   = wv;
          A_DBNC:  dbnc_n = wv;
          A_IEM:   iem_n  = wv;
          A_SLEW:  slew_n = wv;
          A_DRV:   drv_n  = wv;
          A_BLK0:  blk_n[0] = wv;
          A_BLK1:  blk_n[1] = wv;
          A_BLK2:  blk_n[2] = wv;
          A_BLK3:  blk_n[3] = wv;
          A_DOS:   dout_n = dout_q | wv;
          A_DOC:   dout_n = dout_q & ~wv;
          A_OES:   oe_n   = oe_q | wv;
          A_OEC:   oe_n   = oe_q & ~wv;
          A_EVTYP: begin evtyp_n = wv;          evt_w = 1'b1; end
          A_EVBE:  begin evbe_n  = wv;          evt_w = 1'b1; end
          A_EVEN:  begin even_n  = wv;          evt_w = 1'b1; end
          A_EVENS: begin even_n  = even_q | wv;  evt_w = 1'b1; end
          A_EVENC: begin even_n  = even_q & ~wv; evt_w = 1'b1; end
          A_EVST:  begin evst_clr = wv;         evt_w = 1'b1; end
          default: ;
        endcase
      end
    end
    evst_n = (evst_q & ~evst_clr) | evt_hit_i;
  end

  wire pins_chg = {pol_n, dout_n, oe_n, otyp_n, pu_n, pd_n, iem_n}
               != {pol_q, dout_q, oe_q, otyp_q, pu_q, pd_q, iem_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pol_q <= '0; dout_q <= '0; oe_q <= '0; otyp_q <= '0; mux_q <= '0;
      pu_q <= PU_RST; pd_q <= PD_RST; dbnc_q <= '0;
      evtyp_q <= '0; evbe_q <= '0; even_q <= '0; evst_q <= '0; iem_q <= '0;
      slew_q <= SLEW_RST; drv_q <= DRV_RST; blk_q <= '0;
      lk1_q <= 1'b0; lk2_q <= '0;
      pins_upd_q <= 1'b0; evts_upd_q <= 1'b0;
    end else begin
      pol_q <= pol_n; dout_q <= dout_n; oe_q <= oe_n; otyp_q <= otyp_n; mux_q <= mux_n;
      pu_q <= pu_n; pd_q <= pd_n; dbnc_q <= dbnc_n;
      evtyp_q <= evtyp_n; evbe_q <= evbe_n; even_q <= even_n; evst_q <= evst_n; iem_q <= iem_n;
      slew_q <= slew_n; drv_q <= drv_n; blk_q <= blk_n;
      lk1_q <= lk1_n; lk2_q <= lk2_n;
      pins_upd_q <= pins_chg;
      evts_upd_q <= evt_w;
    end
  end

  always_comb begin
    rd_val = '0;
    if (aligned) begin
      case (bus_addr)
        A_LOCK1: rd_val = {31'b0, lk1_q};
        A_DIN:   rd_val = 32'(din_i);
        A_POL:   rd_val = 32'(pol_q);
        A_DOUT:  rd_val = 32'(dout_q);
        A_OE:    rd_val = 32'(oe_q);
        A_OTYP:  rd_val = 32'(otyp_q);
        A_MUX:   rd_val = 32'(mux_q);
        A_PU:    rd_val = 32'(pu_q);
        A_PD:    rd_val = 32'(pd_q);
        A_DBNC:  rd_val = 32'(dbnc_q);
        A_EVTYP: rd_val = 32'(evtyp_q);
        A_EVBE:  rd_val = 32'(evbe_q);
        A_BLK0:  rd_val = 32'(blk_q[0]);
        A_BLK1:  rd_val = 32'(blk_q[1]);
        A_BLK2:  rd_val = 32'(blk_q[2]);
        A_BLK3:  rd_val = 32'(blk_q[3]);
        A_EVEN:  rd_val = 32'(even_q);
        A_EVST:  rd_val = 32'(evst_q);
        A_IEM:   rd_val = 32'(iem_q);
        A_SLEW:  rd_val = 32'(slew_q);
        A_DRV:   rd_val = 32'(drv_q);
        default: rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_val;
  end

  assign pol_o = pol_q;     assign dout_o = dout_q;   assign oe_o = oe_q;
  assign otyp_o = otyp_q;   assign mux_o = mux_q;     assign pu_o = pu_q;
  assign pd_o = pd_q;       assign dbnc_o = dbnc_q;   assign evtyp_o = evtyp_q;
  assign evbe_o = evbe_q;   assign even_o = even_q;   assign evst_o = evst_q;
  assign iem_o = iem_q;     assign slew_o = slew_q;   assign drv_o = drv_q;
  assign locked_o = lk1_q;
  assign pins_upd_o = pins_upd_q;
  assign evts_upd_o = evts_upd_q;
endmodule

// File: rtl/gpio_lock_bank_chk.sv
module gpio_lock_bank_chk #(
  parameter int NPINS = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [31:0]       bus_wdata,
  input logic              bus_re,
  input logic [31:0]       bus_rdata,
  input logic [NPINS-1:0]  pol_o,
  input logic [NPINS-1:0]  dout_o,
  input logic [NPINS-1:0]  oe_o,
  input logic [NPINS-1:0]  pu_o,
  input logic [NPINS-1:0]  even_o,
  input logic              locked_o,
  input logic              pins_upd_o,
  input logic              evts_upd_o
);
  function automatic logic is_wo(input logic [ADDR_W-1:0] a);
    return a == ADDR_W'(8'h44) || a == ADDR_W'(8'h48) || a == ADDR_W'(8'h68) ||
           a == ADDR_W'(8'h6C) || a == ADDR_W'(8'h70) || a == ADDR_W'(8'h74) ||
           a == ADDR_W'(8'h7C);
  endfunction

  p_lock_on_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked_o && bus_we && (bus_addr == ADDR_W'(8'h00) || bus_addr == ADDR_W'(8'h7C)))
    |=> locked_o);

  p_stay_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_o && !(bus_we && bus_addr == ADDR_W'(8'h00))) |=> locked_o);

  p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |=> ($stable(pol_o) && $stable(dout_o) && $stable(oe_o) &&
                  $stable(pu_o) && $stable(even_o)));

  p_unlock_key_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked_o) |-> ($past(bus_we) && $past(bus_addr) == ADDR_W'(8'h00) &&
                         $past(bus_wdata) == 32'hC0DE_FA73));

  p_pins_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pins_upd_o |-> ($past(bus_we) && !$past(locked_o)));

  p_dout_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout_o) |-> pins_upd_o);

  p_evts_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    evts_upd_o |-> ($past(bus_we) && !$past(locked_o)));

  p_wo_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_re) && is_wo($past(bus_addr))) |-> bus_rdata == 32'h0);
endmodule

bind gpio_lock_bank gpio_lock_bank_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
  .pol_o(pol_o), .dout_o(dout_o), .oe_o(oe_o), .pu_o(pu_o), .even_o(even_o),
  .locked_o(locked_o), .pins_upd_o(pins_upd_o), .evts_upd_o(evts_upd_o)
);

// File: tb/gpio_lock_bank_tb_top.sv
module gpio_lock_bank_tb_top;
  localparam logic [31:0] PU_R = 32'h0000_00F0;
  localparam logic [31:0] PD_R = 32'h0F00_0000;
  localparam logic [31:0] SL_R = 32'h8000_0001;
  localparam logic [31:0] DR_R = 32'h0001_8000;
  localparam logic [31:0] K1 = 32'hC0DE_FA73;
  localparam logic [31:0] K2 = 32'hC0DE_1248;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [31:0] din_i = 32'h1234_5678, evt_hit_i = '0;
  logic [31:0] pol_o, dout_o, oe_o, otyp_o, mux_o, pu_o, pd_o, dbnc_o;
  logic [31:0] evtyp_o, evbe_o, even_o, evst_o, iem_o, slew_o, drv_o;
  logic locked_o, pins_upd_o, evts_upd_o;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_lock_bank #(.NPINS(32), .ADDR_W(8), .PU_RST(PU_R), .PD_RST(PD_R),
                   .SLEW_RST(SL_R), .DRV_RST(DR_R)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .din_i(din_i), .evt_hit_i(evt_hit_i),
    .pol_o(pol_o), .dout_o(dout_o), .oe_o(oe_o), .otyp_o(otyp_o), .mux_o(mux_o),
    .pu_o(pu_o), .pd_o(pd_o), .dbnc_o(dbnc_o), .evtyp_o(evtyp_o), .evbe_o(evbe_o),
    .even_o(even_o), .evst_o(evst_o), .iem_o(iem_o), .slew_o(slew_o), .drv_o(drv_o),
    .locked_o(locked_o), .pins_upd_o(pins_upd_o), .evts_upd_o(evts_upd_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_re = 1'b1;
    @(negedge clk); bus_re = 1'b0; d = bus_rdata;
  endtask

  function automatic logic [31:0] pat(input int k);
    return 32'hA5A5_A5A5 ^ (32'(k) * 32'h0101_0101) ^ 32'h1;
  endfunction

  function automatic bit is_rw(input int k);
    return (k >= 2 && k <= 16) || (k >= 22 && k <= 24);
  endfunction

  function automatic bit skip_w(input int k);
    return k == 0 || k == 31 || k == 17 || k == 18 || (k >= 26 && k <= 29);
  endfunction

  function automatic logic [31:0] rst_exp(input int k);
    case (k)
      1: return 32'h1234_5678;
      7: return PU_R;
      8: return PD_R;
      23: return SL_R;
      24: return DR_R;
      default: return 32'h0;
    endcase
  endfunction

  task automatic read_sweep(input string req);
    logic [31:0] v;
    for (int k = 0; k < 32; k++) begin
      rd(8'(k * 4), v);
      if (k == 0) chk({req, " lock word"}, v, {31'b0, locked_o});
      else if (k == 1) chk({req, " din"}, v, din_i);
      else if (is_rw(k)) chk({req, " rw"}, v, pat(k));
      else chk({req, " zero word"}, v, 32'h0);
    end
  endtask

  initial begin
    logic [31:0] v, e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    for (int k = 0; k < 32; k++) begin
      rd(8'(k * 4), v);
      chk("R1 reset read", v, rst_exp(k));
    end
    chk("R1 locked_o", {31'b0, locked_o}, 32'h0);
    chk("R1 pu_o", pu_o, PU_R);
    chk("R1 pd_o", pd_o, PD_R);
    chk("R1 slew_o", slew_o, SL_R);
    chk("R1 drv_o", drv_o, DR_R);
    chk("R1 dout_o", dout_o, 32'h0);

    // R2/R3 unlocked write sweep
    for (int k = 1; k < 32; k++) if (!skip_w(k)) wr(8'(k * 4), pat(k));
    read_sweep("R2/R3 unlocked");
    chk("R2 pol_o", pol_o, pat(2));
    chk("R2 oe_o", oe_o, pat(4));
    chk("R2 iem_o", iem_o, pat(22));
    chk("R2 drv_o", drv_o, pat(24));
    din_i = 32'h0BAD_F00D;
    rd(8'h04, v);
    chk("R3 din live", v, 32'h0BAD_F00D);

    // R4 lock via second key address
    wr(8'h7C, 32'h1111_2222);
    chk("R4 locked_o", {31'b0, locked_o}, 32'h1);
    rd(8'h00, v);
    chk("R4 lock word reads 1", v, 32'h1);
    // R5 writes blocked while locked
    for (int k = 1; k < 31; k++) begin
      wr(8'(k * 4), ~pat(k));
      chk("R5 no pins strobe when locked", {31'b0, pins_upd_o}, 32'h0);
      chk("R5 no events strobe when locked", {31'b0, evts_upd_o}, 32'h0);
    end
    read_sweep("R5 locked");
    // R6 key checks
    wr(8'h7C, K2); wr(8'h00, 32'h0);
    chk("R6 wrong first key", {31'b0, locked_o}, 32'h1);
    wr(8'h7C, 32'h0); wr(8'h00, K1);
    chk("R6 wrong second key", {31'b0, locked_o}, 32'h1);
    wr(8'h7C, K2); wr(8'h7C, 32'h5); wr(8'h00, K1);
    chk("R6 second key overwritten", {31'b0, locked_o}, 32'h1);
    wr(8'h7C, K2); wr(8'h00, K1);
    chk("R6 unlock", {31'b0, locked_o}, 32'h0);
    rd(8'h00, v);
    chk("R6 lock word reads 0", v, 32'h0);
    wr(8'h00, 32'h0);
    chk("R4 lock via first word", {31'b0, locked_o}, 32'h1);
    wr(8'h00, K1);
    chk("R6 key cleared on unlock/lock", {31'b0, locked_o}, 32'h1);
    wr(8'h7C, K2); wr(8'h00, K1);
    chk("R6 unlock again", {31'b0, locked_o}, 32'h0);

    // R7 aliases
    e = pat(3) | 32'h0000_FFFF;
    wr(8'h68, 32'h0000_FFFF);
    chk("R7 out set", dout_o, e);
    e = e & ~32'hFF00_0000;
    wr(8'h6C, 32'hFF00_0000);
    rd(8'h0C, v);
    chk("R7 out clear", v, e);
    e = pat(4) | 32'h00F0_00F0;
    wr(8'h70, 32'h00F0_00F0);
    chk("R7 oe set", oe_o, e);
    e = e & ~32'h0000_0F0F;
    wr(8'h74, 32'h0000_0F0F);
    chk("R7 oe clear", oe_o, e);
    e = pat(16) | 32'h8000_0003;
    wr(8'h44, 32'h8000_0003);
    chk("R7 event enable set", even_o, e);
    chk("R10 strobe after enable set", {31'b0, evts_upd_o}, 32'h1);
    e = e & ~32'h0000_00FF;
    wr(8'h48, 32'h0000_00FF);
    rd(8'h40, v);
    chk("R7 event enable clear", v, e);

    // R8 event status
    @(negedge clk); evt_hit_i = 32'h0000_000F;
    @(negedge clk); evt_hit_i = 32'h0;
    rd(8'h4C, v);
    chk("R8 status set", v, 32'h0000_000F);
    wr(8'h4C, 32'h0000_0005);
    chk("R8 status w1c", evst_o, 32'h0000_000A);
    @(negedge clk); bus_addr = 8'h4C; bus_wdata = 32'h3; bus_we = 1'b1; evt_hit_i = 32'h1;
    @(negedge clk); bus_we = 1'b0; evt_hit_i = 32'h0;
    chk("R8 hit wins over clear", evst_o, 32'h0000_0009);
    wr(8'h00, 32'h0);
    @(negedge clk); evt_hit_i = 32'h0000_0010;
    @(negedge clk); evt_hit_i = 32'h0;
    wr(8'h4C, 32'hFFFF_FFFF);
    chk("R8 hits while locked, clear blocked", evst_o, 32'h0000_0019);
    wr(8'h7C, K2); wr(8'h00, K1);

    // R9 / R10 strobes
    e = pol_o ^ 32'h1;
    wr(8'h08, e);
    chk("R9 strobe on change", {31'b0, pins_upd_o}, 32'h1);
    @(negedge clk);
    chk("R9 strobe one cycle", {31'b0, pins_upd_o}, 32'h0);
    wr(8'h08, e);
    chk("R9 no strobe same value", {31'b0, pins_upd_o}, 32'h0);
    wr(8'h1C, 32'h0);
    chk("R9 strobe pull-up change", {31'b0, pins_upd_o}, 32'h1);
    wr(8'h18, 32'h7777_7777);
    chk("R9 mux no pins strobe", {31'b0, pins_upd_o}, 32'h0);
    chk("R10 mux no events strobe", {31'b0, evts_upd_o}, 32'h0);
    wr(8'h28, evtyp_o);
    chk("R10 events strobe", {31'b0, evts_upd_o}, 32'h1);
    chk("R9 event write no pins strobe", {31'b0, pins_upd_o}, 32'h0);
    @(negedge clk);
    chk("R10 events strobe one cycle", {31'b0, evts_upd_o}, 32'h0);

    // R11 read latency and hold
    @(negedge clk); bus_addr = 8'h18; bus_re = 1'b1;
    @(negedge clk); bus_re = 1'b0; bus_addr = 8'h08;
    chk("R11 data after one cycle", bus_rdata, 32'h7777_7777);
    @(negedge clk);
    chk("R11 data held", bus_rdata, 32'h7777_7777);

    // R12 misaligned
    wr(8'h0A, 32'hDEAD_BEEF);
    chk("R12 misaligned write ignored", pol_o, e);
    rd(8'h09, v);
    chk("R12 misaligned read zero", v, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule